// File: doc/BRIEF.md
# SPI Status Flag and Interrupt Unit

This unit holds the sticky status flags of an SPI controller and produces one masked interrupt line from them. Single-cycle event strobes come in from the serializer: a received word was loaded, the transmit holding register was handed to the shifter, a mode fault was seen, and a transmit-register write happened. A shifter-busy level also comes from the serializer, and the raw slave-select pin comes in unsynchronized. The unit turns these into a 10-bit status word. Bus read strobes clear the flags that read-clear, and set and clear writes maintain an interrupt mask.

The flags for receive overrun, mode fault and slave-select rise stay set until the status register is read. The receive-full flag clears when the receive register is read. The transmit-empty flag follows the enable state and the holding register. The transmitter-idle flag waits for a programmable inter-transfer delay before it rises. Four DMA channel flags pass straight through into the word. When a set event and a read-clear fall in the same cycle, the set wins, so no event is lost.

Top module: `spi_stat_irq`

## Requirements
- R1: After reset, status reads 10'h200: only bit 9 (transmitter idle) is high, with the DMA inputs low. The mask reads 0 and irq is low.
- R2: Bit 0 (receive full) is set by rx_load and cleared by rd_rxdata. When both come in the same cycle it stays set.
- R3: Bit 3 (overrun) is set when rx_load arrives while bit 0 is already high and rd_rxdata is low. It survives a receive-register read and clears only on rd_status.
- R4: Bit 2 (mode fault) is set by mode_fault and holds until rd_status. A mode_fault arriving with rd_status in the same cycle leaves it set.
- R5: Bit 1 (transmit empty) is 0 at reset and stays 0 while the unit is disabled, even if tx_handoff pulses. cmd_enable forces it to 1 and cmd_disable forces it to 0. While enabled, tx_wr clears it and tx_handoff sets it.
- R6: ss_pin passes through two synchronizer flops. A rising edge sets bit 8, three clock edges after the pin changes. A falling edge sets nothing. The bit clears on rd_status.
- R7: Bit 9 (transmitter idle) clears on tx_wr. It sets only when bit 1 is high, shifter_busy is low, and xfer_dly further cycles have passed with the shifter idle. With a delay of D, it rises on the (D+1)-th edge after shifter_busy is first sampled low.
- R8: Bits 7:4 equal dma_flags[3:0] combinationally (dma_flags[0] appears on bit 4).
- R9: A 1 in ier_data sets that mask bit and a 1 in idr_data clears it. Zeros have no effect. If the same bit is written to both in one cycle, the clear wins.
- R10: irq is high exactly when some status bit and its mask bit are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_load | input | 1 | Serializer loaded a word into the receive register |
| tx_wr | input | 1 | Bus write to the transmit register |
| tx_handoff | input | 1 | Holding register moved into the shifter |
| shifter_busy | input | 1 | Shifter is transferring |
| mode_fault | input | 1 | Mode fault event |
| ss_pin | input | 1 | Raw slave-select pin, asynchronous |
| dma_flags | input | 4 | DMA end and buffer flags, passed through |
| xfer_dly | input | DLY_W | Inter-transfer delay in clock cycles |
| rd_status | input | 1 | Status register read strobe |
| rd_rxdata | input | 1 | Receive register read strobe |
| cmd_enable | input | 1 | Enable command |
| cmd_disable | input | 1 | Disable command |
| ier_wr | input | 1 | Interrupt-enable write strobe |
| ier_data | input | 10 | Mask bits to set |
| idr_wr | input | 1 | Interrupt-disable write strobe |
| idr_data | input | 10 | Mask bits to clear |
| status | output | 10 | Status word |
| mask | output | 10 | Interrupt mask |
| irq | output | 1 | Masked interrupt |

## Verification
The receive path is driven in three ways: a single load, two loads with no read between them, and a load that coincides with a read. These separate a plain receive-full from an overrun, and they show whether a same-cycle read drops the event. The transmit path is exercised before and after enable and with inter-transfer delays of zero and three cycles, which exposes off-by-one errors in the delay counter. The slave-select pin is toggled low and then high, which shows both the synchronizer latency and that only rising edges count. The mask is written with one-bits, zero-bits and a colliding set and clear, and each case is paired with a mode fault to show the interrupt following mask and status together.

// File: rtl/spi_stat_pkg.sv
// Shared widths and status bit positions for the SPI status unit.
// Assumes: positions are fixed because software decodes them.
package spi_stat_pkg;
    localparam int STAT_W   = 10;
    localparam int DMA_W    = 4;
    localparam int B_RXF    = 0;
    localparam int B_TDRE   = 1;
    localparam int B_MODF   = 2;
    localparam int B_OVR    = 3;
    localparam int B_DMA_LO = 4;
    localparam int B_SSRISE = 8;
    localparam int B_IDLE   = 9;
endpackage

// File: rtl/stat_sticky_bit.sv
// One sticky flag: set by an event, cleared by a read strobe, set wins.
// Assumes: set and clr are single-cycle strobes in the clk domain.
module stat_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold the flag; a set in the clearing cycle keeps it high.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/stat_ss_sync.sv
// Synchronizes the slave-select pin and pulses on its rising edge.
// Assumes: the pin idles high, so the flops reset high (no false edge).
module stat_ss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the pin through the synchronizer and keep one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            last_q <= sync_q[STAGES-1];
        end
    end

    // Edge pulse from the synchronized level.
    assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/stat_tx_track.sv
// Tracks enable state, transmit-empty and transmitter-idle with its delay.
// Assumes: strobes are single-cycle; shifter_busy is a level.
module stat_tx_track #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_enable,
    input  logic             cmd_disable,
    input  logic             tx_wr,
    input  logic             tx_handoff,
    input  logic             shifter_busy,
    input  logic [DLY_W-1:0] xfer_dly,
    output logic             tdre,
    output logic             idle
);
    logic             en_q;
    logic [DLY_W-1:0] dly_cnt;

    // Enable state and transmit-empty; disable dominates, then enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            tdre <= 1'b0;
        end else if (cmd_disable) begin
            en_q <= 1'b0;
            tdre <= 1'b0;
        end else if (cmd_enable) begin
            en_q <= 1'b1;
            tdre <= 1'b1;
        end else if (!en_q) begin
            tdre <= 1'b0;
        end else if (tx_handoff) begin
            tdre <= 1'b1;
        end else if (tx_wr) begin
            tdre <= 1'b0;
        end
    end

    // Delay counter: reloads while busy or on a write, then counts down.
    always_ff @(posedge clk) begin
        if (!rst_n)                     dly_cnt <= '0;
        else if (tx_wr || shifter_busy) dly_cnt <= xfer_dly;
        else if (dly_cnt != '0)         dly_cnt <= dly_cnt - 1'b1;
    end

    // Idle flag: cleared by a write, set once everything has drained.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idle <= 1'b1;
        else if (tx_wr)
            idle <= 1'b0;
        else if (tdre && !shifter_busy && dly_cnt == '0)
            idle <= 1'b1;
    end
endmodule

// File: rtl/stat_mask_reg.sv
// Interrupt mask with separate set and clear writes; clear wins.
// Assumes: data is only meaningful while its write strobe is high.
module stat_mask_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_wr,
    input  logic [W-1:0] set_data,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] mask
);
    logic [W-1:0] set_v, clr_v;

    // Qualify the write data with their strobes.
    assign set_v = set_wr ? set_data : '0;
    assign clr_v = clr_wr ? clr_data : '0;

    // Apply the sets, then the clears.
    always_ff @(posedge clk) begin
        if (!rst_n) mask <= '0;
        else        mask <= (mask | set_v) & ~clr_v;
    end
endmodule

// File: rtl/spi_stat_irq.sv
// Top of the SPI status unit: assembles the status word and the interrupt.
// Assumes: all strobes are synchronous to clk except ss_pin.
module spi_stat_irq
    import spi_stat_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_load,
    input  logic              tx_wr,
    input  logic              tx_handoff,
    input  logic              shifter_busy,
    input  logic              mode_fault,
    input  logic              ss_pin,
    input  logic [DMA_W-1:0]  dma_flags,
    input  logic [DLY_W-1:0]  xfer_dly,
    input  logic              rd_status,
    input  logic              rd_rxdata,
    input  logic              cmd_enable,
    input  logic              cmd_disable,
    input  logic              ier_wr,
    input  logic [STAT_W-1:0] ier_data,
    input  logic              idr_wr,
    input  logic [STAT_W-1:0] idr_data,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] mask,
    output logic              irq
);
    logic rxf, ovr, modf, ssrise, tdre, idle, ss_edge, ovr_evt;

    // An overrun is a load while an unread word is still held.
    assign ovr_evt = rx_load && rxf && !rd_rxdata;

    stat_sticky_bit u_rxf  (.clk(clk), .rst_n(rst_n), .set(rx_load),
                            .clr(rd_rxdata), .q(rxf));
    stat_sticky_bit u_ovr  (.clk(clk), .rst_n(rst_n), .set(ovr_evt),
                            .clr(rd_status), .q(ovr));
    stat_sticky_bit u_modf (.clk(clk), .rst_n(rst_n), .set(mode_fault),
                            .clr(rd_status), .q(modf));
    stat_sticky_bit u_ssr  (.clk(clk), .rst_n(rst_n), .set(ss_edge),
                            .clr(rd_status), .q(ssrise));

    stat_ss_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ss_pin), .rise(ss_edge));

    stat_tx_track #(.DLY_W(DLY_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .cmd_enable(cmd_enable),
        .cmd_disable(cmd_disable), .tx_wr(tx_wr), .tx_handoff(tx_handoff),
        .shifter_busy(shifter_busy), .xfer_dly(xfer_dly),
        .tdre(tdre), .idle(idle));

    stat_mask_reg #(.W(STAT_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .set_wr(ier_wr), .set_data(ier_data),
        .clr_wr(idr_wr), .clr_data(idr_data), .mask(mask));

    // Place each flag at its fixed position in the status word.
    always_comb begin
        status                         = '0;
        status[B_RXF]                  = rxf;
        status[B_TDRE]                 = tdre;
        status[B_MODF]                 = modf;
        status[B_OVR]                  = ovr;
        status[B_DMA_LO +: DMA_W]      = dma_flags;
        status[B_SSRISE]               = ssrise;
        status[B_IDLE]                 = idle;
    end

    // Interrupt: any enabled flag that is set.
    assign irq = |(status & mask);
endmodule

// File: rtl/spi_stat_irq_chk.sv
// Property checks on the SPI status unit, bound to every instance.
module spi_stat_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_load,
    input logic       rd_rxdata,
    input logic       rd_status,
    input logic       mode_fault,
    input logic       cmd_disable,
    input logic       tx_wr,
    input logic       ier_wr,
    input logic [9:0] ier_data,
    input logic       idr_wr,
    input logic [9:0] status,
    input logic [9:0] mask,
    input logic       irq
);
    a_r2_rxf_set: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |=> status[0]);
    a_r3_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load && status[0] && !rd_rxdata) |=> status[3]);
    a_r4_modf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && !rd_status) |=> status[2]);
    a_r5_tdre_off: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_disable |=> !status[1]);
    a_r7_idle_clr: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !status[9]);
    a_r9_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_wr && !idr_wr) |=> ((mask & $past(ier_data)) == $past(ier_data)));
    a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 10'h000) |-> !irq);
endmodule

bind spi_stat_irq spi_stat_irq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_load(rx_load), .rd_rxdata(rd_rxdata),
    .rd_status(rd_status), .mode_fault(mode_fault), .cmd_disable(cmd_disable),
    .tx_wr(tx_wr), .ier_wr(ier_wr), .ier_data(ier_data), .idr_wr(idr_wr),
    .status(status), .mask(mask), .irq(irq));

// File: tb/spi_stat_irq_tb.sv
module spi_stat_irq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_load = 0, tx_wr = 0, tx_handoff = 0, shifter_busy = 0;
    logic       mode_fault = 0, ss_pin = 1, rd_status = 0, rd_rxdata = 0;
    logic       cmd_enable = 0, cmd_disable = 0, ier_wr = 0, idr_wr = 0;
    logic [3:0] dma_flags = 4'h0;
    logic [7:0] xfer_dly = 8'd0;
    logic [9:0] ier_data = '0, idr_data = '0;
    logic [9:0] status, mask;
    logic       irq;
    int         n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    spi_stat_irq u_dut (
        .clk(clk), .rst_n(rst_n), .rx_load(rx_load), .tx_wr(tx_wr),
        .tx_handoff(tx_handoff), .shifter_busy(shifter_busy),
        .mode_fault(mode_fault), .ss_pin(ss_pin), .dma_flags(dma_flags),
        .xfer_dly(xfer_dly), .rd_status(rd_status), .rd_rxdata(rd_rxdata),
        .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
        .ier_wr(ier_wr), .ier_data(ier_data), .idr_wr(idr_wr),
        .idr_data(idr_data), .status(status), .mask(mask), .irq(irq));

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 0; tick(); tick(); rst_n = 1; tick();
        check("R1 status", 32'(status), 32'h200);
        check("R1 mask", 32'(mask), 0);
        check("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_tdre();
        tx_handoff = 1; tick(); tx_handoff = 0;
        check("R5 disabled handoff", 32'(status[1]), 0);
        cmd_enable = 1; tick(); cmd_enable = 0;
        check("R5 enable", 32'(status[1]), 1);
        tx_wr = 1; tick(); tx_wr = 0;
        check("R5 write clears", 32'(status[1]), 0);
        check("R7 write clears idle", 32'(status[9]), 0);
        tx_handoff = 1; tick(); tx_handoff = 0;
        check("R5 handoff sets", 32'(status[1]), 1);
        cmd_disable = 1; tick(); cmd_disable = 0;
        check("R5 disable", 32'(status[1]), 0);
        cmd_enable = 1; tick(); cmd_enable = 0;
    endtask

    task automatic t_idle(input logic [7:0] d);
        xfer_dly = d;
        tx_wr = 1; tick(); tx_wr = 0;
        tx_handoff = 1; shifter_busy = 1; tick(); tx_handoff = 0;
        tick(); shifter_busy = 0;
        for (int i = 0; i < int'(d); i++) begin
            tick();
            check("R7 idle still low", 32'(status[9]), 0);
        end
        tick();
        check("R7 idle after delay", 32'(status[9]), 1);
    endtask

    task automatic t_rx();
        rx_load = 1; tick(); rx_load = 0;
        check("R2 load sets", 32'(status[0]), 1);
        rd_rxdata = 1; tick(); rd_rxdata = 0;
        check("R2 read clears", 32'(status[0]), 0);
        rx_load = 1; tick();
        rd_rxdata = 1; tick(); rx_load = 0; rd_rxdata = 0;
        check("R2 set wins", 32'(status[0]), 1);
        check("R3 no overrun when read", 32'(status[3]), 0);
        rx_load = 1; tick(); rx_load = 0;
        check("R3 overrun", 32'(status[3]), 1);
        rd_rxdata = 1; tick(); rd_rxdata = 0;
        check("R3 survives rx read", 32'(status[3:0] & 4'b1001), 32'h8);
        rd_status = 1; tick(); rd_status = 0;
        check("R3 status read clears", 32'(status[3]), 0);
    endtask

    task automatic t_modf();
        mode_fault = 1; tick(); mode_fault = 0; tick();
        check("R4 sticky", 32'(status[2]), 1);
        mode_fault = 1; rd_status = 1; tick(); mode_fault = 0; rd_status = 0;
        check("R4 set wins", 32'(status[2]), 1);
        rd_status = 1; tick(); rd_status = 0;
        check("R4 clears", 32'(status[2]), 0);
    endtask

    task automatic t_ss();
        ss_pin = 0; tick(); tick(); tick(); tick();
        check("R6 fall ignored", 32'(status[8]), 0);
        ss_pin = 1; tick();
        check("R6 edge 1", 32'(status[8]), 0);
        tick();
        check("R6 edge 2", 32'(status[8]), 0);
        tick();
        check("R6 edge 3", 32'(status[8]), 1);
        rd_status = 1; tick(); rd_status = 0;
        check("R6 clears", 32'(status[8]), 0);
    endtask

    task automatic t_dma();
        dma_flags = 4'b1010; #1;
        check("R8 passthrough", 32'(status[7:4]), 32'ha);
        dma_flags = 4'b0000; #1;
        check("R8 passthrough low", 32'(status[7:4]), 0);
    endtask

    task automatic t_mask();
        ier_wr = 1; ier_data = 10'h005; tick(); ier_wr = 0;
        check("R9 set", 32'(mask), 32'h005);
        ier_wr = 1; ier_data = 10'h000; tick(); ier_wr = 0;
        check("R9 zero set no effect", 32'(mask), 32'h005);
        idr_wr = 1; idr_data = 10'h001; tick(); idr_wr = 0;
        check("R9 clear", 32'(mask), 32'h004);
        idr_wr = 1; idr_data = 10'h000; tick(); idr_wr = 0;
        check("R9 zero clear no effect", 32'(mask), 32'h004);
        ier_wr = 1; ier_data = 10'h008; idr_wr = 1; idr_data = 10'h008;
        tick(); ier_wr = 0; idr_wr = 0;
        check("R9 clear wins", 32'(mask), 32'h004);
        check("R10 irq low", 32'(irq), 0);
        mode_fault = 1; tick(); mode_fault = 0;
        check("R10 irq high", 32'(irq), 1);
        rd_status = 1; tick(); rd_status = 0;
        check("R10 irq drops", 32'(irq), 0);
    endtask

    initial begin
        t_reset();
        t_tdre();
        t_idle(8'd3);
        t_idle(8'd0);
        t_rx();
        t_modf();
        t_ss();
        t_dma();
        t_mask();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule